// File: doc/BRIEF.md
# Crosswise Array Multiplier with Counter-Based Column Reduction

This block multiplies two unsigned 8-bit operands and returns the full 16-bit product. Every partial product bit is the AND of one multiplicand bit with one multiplier bit. These bits are sorted by weight into 15 columns before any addition begins. Column `i` holds every term whose two bit indices add up to `i`, so the column heights rise from 1 to 8 and then fall back to 1.

Each column with four or more bits goes through a single counter of order four to seven. The counter gives the number of ones among its inputs as a 3-bit binary value. The count's weight-2 and weight-4 bits move one and two columns to the left. Columns with three bits or fewer pass their bits straight through. The one bit left over in the tallest column also passes through. The five resulting rows go through three carry-save levels and then one carry-propagate adder.

The parameter `OUT_REG` selects one of two forms. With `OUT_REG` set, the product is registered for timing. With `OUT_REG` cleared, the block is purely combinational.

Top module: `crosswise_mul`

## Requirements
- R1: `prod_o` equals the unsigned product of `a_i` and `b_i` for all 65536 operand pairs.
- R2: When either operand is zero, the product is zero.
- R3: Each column counter of order N (N = 4, 5, 6, 7) outputs the number of ones among its N inputs as three bits of weight 1, 2 and 4, for every input pattern.
- R4: The largest operands, 255 times 255, give 16'hFE01.
- R5: When both operands have a single bit set, at positions p and q, the product has exactly one bit set, at position p+q.
- R6: With `OUT_REG` = 1, `rst_n` low clears `prod_o` to zero asynchronously, whatever the operands. After reset, `prod_o` shows the product of the operands sampled at the previous rising edge of `clk`. Between edges it holds that value.
- R7: With `OUT_REG` = 0, `prod_o` follows the operands with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a_i | input | 8 | Unsigned multiplicand |
| b_i | input | 8 | Unsigned multiplier |
| prod_o | output | 16 | Unsigned 16-bit product |

## Verification
The block holds no internal state apart from the output register. A wrong partial-product term, a miswired counter carry, or a broken carry-save level shows up as a wrong product in the same evaluation in which the operands that exercise it are applied. In the registered form it shows one clock later. Such faults often affect only some operand pairs: one column, or one counter input pattern. For this reason the combinational form is swept over every operand pair, and each counter order is swept over every input pattern.

// File: rtl/xmul_pkg.sv
package xmul_pkg;
  localparam int OPW    = 8;
  localparam int PRW    = 2 * OPW;
  localparam int NCOL   = 2 * OPW - 1;
  localparam int MAXORD = 7;

  typedef logic [PRW-1:0] row_t;

  // lowest multiplier bit index that contributes to column i
  function automatic int col_lo(int i);
    return (i < OPW) ? 0 : i - OPW + 1;
  endfunction

  // number of AND terms that land in column i
  function automatic int col_h(int i);
    return (i < OPW) ? i + 1 : NCOL - i;
  endfunction
endpackage

// File: rtl/xmul_counter.sv
module xmul_counter #(
  parameter int N = 7
) (
  input  logic [N-1:0] bits_i,
  output logic [2:0]   cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int k = 0; k < N; k++) begin
      cnt_o = cnt_o + {2'b00, bits_i[k]};
    end
    // R3: a count of N inputs never exceeds N
    a_r3_cnt_bound: assert (int'(cnt_o) <= N);
  end
endmodule

// File: rtl/xmul_colstage.sv
module xmul_colstage
  import xmul_pkg::*;
(
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  output row_t           w1_row_o,
  output row_t           pa_row_o,
  output row_t           pb_row_o,
  output row_t           w2_row_o,
  output row_t           w4_row_o
);
  logic [NCOL-1:0] cw1, cw2, cw4, pa, pb;

  for (genvar i = 0; i < NCOL; i++) begin : g_col
    localparam int H  = col_h(i);
    localparam int LO = col_lo(i);
    logic [H-1:0] colv;

    for (genvar t = 0; t < H; t++) begin : g_term
      assign colv[t] = a_i[i-LO-t] & b_i[LO+t];
    end

    if (H >= 4) begin : g_cnt
      localparam int ORD = (H > MAXORD) ? MAXORD : H;
      logic [2:0] cnt;
      xmul_counter #(.N(ORD)) u_cnt (
        .bits_i (colv[ORD-1:0]),
        .cnt_o  (cnt)
      );
      assign cw1[i] = cnt[0];
      assign cw2[i] = cnt[1];
      assign cw4[i] = cnt[2];
      if (H > ORD) begin : g_left
        assign pa[i] = colv[ORD];
      end else begin : g_noleft
        assign pa[i] = 1'b0;
      end
      assign pb[i] = 1'b0;
    end else begin : g_pass
      assign cw1[i] = colv[0];
      assign cw2[i] = 1'b0;
      assign cw4[i] = 1'b0;
      if (H > 1) begin : g_p1
        assign pa[i] = colv[1];
      end else begin : g_np1
        assign pa[i] = 1'b0;
      end
      if (H > 2) begin : g_p2
        assign pb[i] = colv[2];
      end else begin : g_np2
        assign pb[i] = 1'b0;
      end
    end
  end

  always_comb begin
    w1_row_o = {1'b0, cw1};
    pa_row_o = {1'b0, pa};
    pb_row_o = {1'b0, pb};
    w2_row_o = {cw2, 1'b0};
    w4_row_o = {cw4[NCOL-2:0], 2'b00};
  end
endmodule

// File: rtl/xmul_csa.sv
module xmul_csa
  import xmul_pkg::*;
(
  input  row_t x_i,
  input  row_t y_i,
  input  row_t z_i,
  output row_t sum_o,
  output row_t car_o
);
  row_t maj;
  always_comb begin
    maj   = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
    sum_o = x_i ^ y_i ^ z_i;
    car_o = {maj[PRW-2:0], 1'b0};
  end
endmodule

// File: rtl/crosswise_mul.sv
module crosswise_mul
  import xmul_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  output logic [PRW-1:0] prod_o
);
  row_t w1_row, pa_row, pb_row, w2_row, w4_row;
  row_t s1, c1, s2, c2, s3, c3;
  row_t sum_d;

  xmul_colstage u_cols (
    .a_i      (a_i),
    .b_i      (b_i),
    .w1_row_o (w1_row),
    .pa_row_o (pa_row),
    .pb_row_o (pb_row),
    .w2_row_o (w2_row),
    .w4_row_o (w4_row)
  );

  xmul_csa u_csa1 (.x_i(w1_row), .y_i(pa_row), .z_i(pb_row), .sum_o(s1), .car_o(c1));
  xmul_csa u_csa2 (.x_i(s1),     .y_i(c1),     .z_i(w2_row), .sum_o(s2), .car_o(c2));
  xmul_csa u_csa3 (.x_i(s2),     .y_i(c2),     .z_i(w4_row), .sum_o(s3), .car_o(c3));

  always_comb sum_d = s3 + c3;

  // R2: a zero operand yields a zero sum
  a_r2_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (a_i == '0 || b_i == '0) |-> (sum_d == '0));

  // R4: largest operands
  a_r4_max_operands: assert property (@(posedge clk) disable iff (!rst_n)
    (&a_i && &b_i) |-> (sum_d == 16'hFE01));

  // R5: single-bit operands give a single-bit product
  a_r5_single_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(a_i) == 1 && $countones(b_i) == 1) |-> ($countones(sum_d) == 1));

  if (OUT_REG) begin : g_reg
    row_t prod_d, prod_q;
    always_comb prod_d = sum_d;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod_q <= '0;
      else        prod_q <= prod_d;
    end
    assign prod_o = prod_q;

    // R6: registered output carries last edge's product
    a_r6_registered: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && $past(rst_n)) |->
        (prod_o == ({{OPW{1'b0}}, $past(a_i)} * {{OPW{1'b0}}, $past(b_i)})));
  end else begin : g_comb
    assign prod_o = sum_d;

    // R1: combinational product matches the operands
    a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
      prod_o == ({{OPW{1'b0}}, a_i} * {{OPW{1'b0}}, b_i}));
  end
endmodule

// File: tb/tb_crosswise_mul.sv
module tb_crosswise_mul;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  ra, rb, ca, cb;
  logic [15:0] rprod, cprod;
  logic [3:0]  v4;
  logic [4:0]  v5;
  logic [5:0]  v6;
  logic [6:0]  v7;
  logic [2:0]  n4, n5, n6, n7;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  crosswise_mul #(.OUT_REG(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .a_i(ra), .b_i(rb), .prod_o(rprod));
  crosswise_mul #(.OUT_REG(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n), .a_i(ca), .b_i(cb), .prod_o(cprod));

  xmul_counter #(.N(4)) u_k4 (.bits_i(v4), .cnt_o(n4));
  xmul_counter #(.N(5)) u_k5 (.bits_i(v5), .cnt_o(n5));
  xmul_counter #(.N(6)) u_k6 (.bits_i(v6), .cnt_o(n6));
  xmul_counter #(.N(7)) u_k7 (.bits_i(v7), .cnt_o(n7));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mul_ref(input logic [7:0] x, input logic [7:0] y);
    int r = 0;
    for (int k = 0; k < 8; k++) if (y[k]) r += int'(x) << k;
    return r[15:0];
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; ra = 8'hA5; rb = 8'h3C; ca = 8'h00; cb = 8'h00;
    v4 = '0; v5 = '0; v6 = '0; v7 = '0;
    repeat (3) @(negedge clk);
    chk("R6 reset clears output", rprod, 16'h0000);
    rst_n = 1'b1;
  endtask

  task automatic t_counters();
    for (int p = 0; p < 128; p++) begin
      logic [6:0] pat = p[6:0];
      int pc = 0;
      v4 = pat[3:0]; v5 = pat[4:0]; v6 = pat[5:0]; v7 = pat;
      #1;
      for (int k = 0; k < 4; k++) pc += int'(pat[k]);
      chk("R3 4-input counter", {13'b0, n4}, pc[15:0]);
      for (int k = 4; k < 5; k++) pc += int'(pat[k]);
      chk("R3 5-input counter", {13'b0, n5}, pc[15:0]);
      for (int k = 5; k < 6; k++) pc += int'(pat[k]);
      chk("R3 6-input counter", {13'b0, n6}, pc[15:0]);
      for (int k = 6; k < 7; k++) pc += int'(pat[k]);
      chk("R3 7-input counter", {13'b0, n7}, pc[15:0]);
    end
  endtask

  task automatic t_exhaustive();
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        ca = x[7:0]; cb = y[7:0];
        #1;
        chk("R1 R7 full sweep", cprod, mul_ref(ca, cb));
      end
    end
  endtask

  task automatic t_corners();
    for (int x = 0; x < 256; x += 17) begin
      ca = x[7:0]; cb = 8'h00; #1;
      chk("R2 zero multiplier", cprod, 16'h0000);
      ca = 8'h00; cb = x[7:0]; #1;
      chk("R2 zero multiplicand", cprod, 16'h0000);
    end
    ca = 8'hFF; cb = 8'hFF; #1;
    chk("R4 max operands", cprod, 16'hFE01);
    for (int p = 0; p < 8; p++) begin
      for (int q = 0; q < 8; q++) begin
        ca = 8'(1 << p); cb = 8'(1 << q); #1;
        chk("R5 single-bit operands", cprod, 16'(1 << (p + q)));
      end
    end
  endtask

  task automatic t_registered();
    logic [15:0] prev;
    logic [7:0] xs[6] = '{8'h00, 8'hFF, 8'h80, 8'h0F, 8'hD3, 8'h01};
    logic [7:0] ys[6] = '{8'h7E, 8'hFF, 8'h80, 8'hF0, 8'h5A, 8'hFF};
    @(negedge clk);
    ra = 8'h11; rb = 8'h22;
    @(negedge clk);
    prev = mul_ref(8'h11, 8'h22);
    chk("R6 first product after reset", rprod, prev);
    for (int i = 0; i < 6; i++) begin
      ra = xs[i]; rb = ys[i];
      #3;
      chk("R6 holds between edges", rprod, prev);
      @(negedge clk);
      prev = mul_ref(xs[i], ys[i]);
      chk("R6 product one edge later", rprod, prev);
    end
    ra = 8'hC7; rb = 8'h9B;
    #3;
    rst_n = 1'b0;
    #1;
    chk("R6 async reset mid-cycle", rprod, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_counters();
    t_corners();
    t_exhaustive();
    t_registered();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule